// File: doc/BRIEF.md
# Double-Data-Rate Two-Beat Common-I/O SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM with one shared data path that moves two data beats per command, one on each half of the main clock. It runs from a single clock `clk_hc` whose rising edges stand for the alternating K and K# edges of the device. An internal phase flag tracks which is which: the first edge after reset is a K edge. Commands (load, read/write select, address) are taken only at K edges. Write data arrives late, on the two edges after the command. Read data leaves five edges (2.5 K cycles) after the command. The model drives echo clocks, a read-data valid strobe and a termination-enable output that turns off around driven read data.

Every array word is twice the width of the data bus. A write gathers its two beats, each with its own active-low byte enables, and stores one merged word. The shared data bus is split into `dq_in`, `dq_out` and `dq_oe` so that the model stays synthesizable. A board-level wrapper joins them into a tristate bus. A memory-controller test environment uses the model as a cycle-accurate target.

Top module: `ddr_b2_sram_model`

## Requirements
- R1: At a K edge, `ld_n`=0 with `rw`=1 is a read, `ld_n`=0 with `rw`=0 is a write, and `ld_n`=1 is a deselect, which moves no data and leaves the array unchanged. `ld_n`, `rw` and `addr` are ignored at K# edges.
- R2: The first `clk_hc` edge after reset is a K edge, and edges alternate K, K#. After a K edge `cq`=1, after a K# edge `cq`=0, and `cq_n` is always the complement of `cq`.
- R3: For a write commanded at K edge n, beat 1 is taken from `dq_in` at edge n+1 (K#) and lands in word bits [W-1:0]. Beat 2 is taken at edge n+2 (K) and lands in bits [2W-1:W].
- R4: `bw_n[b]` is sampled with each write beat. When it is 1, bits [9b+8:9b] of that beat are not written and the stored byte keeps its value. `dq_in` and `bw_n` have no effect at edges that carry no write beat.
- R5: For a read commanded at edge n, `dq_out` carries word bits [W-1:0] after edge n+5 and bits [2W-1:W] after edge n+6, with `dq_oe`=1 during both beats.
- R6: A new command may be issued at every K edge. Back-to-back reads give an unbroken stream of beats, and back-to-back writes each store their own data.
- R7: A read returns the array contents including every write commanded at an earlier K edge, and excluding every write commanded later.
- R8: When no read beat is due, including after a read followed by deselects, `dq_oe`=0 and `dq_out`=0. The read burst always completes.
- R9: `qvalid` is 1 exactly when a read beat is on `dq_out`, for exactly two consecutive half-cycles per read.
- R10: After each edge, `term_en` equals `odt_en` sampled at that edge, except that it is 0 from the half-cycle before a read's first beat until the half-cycle after its last beat.
- R11: While `rst_n`=0, `dq_oe`, `qvalid`, `term_en`, `cq` and `dq_out` are 0, and `cq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hc | input | 1 | Half-cycle clock; each rising edge is a K or a K# edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low command load |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| bw_n | input | NBYTES | Active-low byte write enables, per beat |
| dq_in | input | BYTE_W*NBYTES | Write data beat |
| odt_en | input | 1 | Request for input termination |
| dq_out | output | BYTE_W*NBYTES | Read data beat |
| dq_oe | output | 1 | Data output enable |
| qvalid | output | 1 | Read beat valid |
| term_en | output | 1 | Data input termination enable |
| cq | output | 1 | Echo clock, high in the half-cycle after K |
| cq_n | output | 1 | Complementary echo clock |

## Verification
The assertions take for granted that inputs change only between edges and that reset is released so that the next edge is the K edge, which fixes the phase the echo clocks are checked against. The array is not reset, so the data checks hold only for words that have already been written. The stimulus drives every input on falling edges of `clk_hc`. It writes every address at full enable before any read, and after that it mixes reads, writes and deselects with random masks and random junk on K# command inputs and non-beat data edges. `odt_en` is held high for the first half of the run and toggles in the second half.

// File: rtl/ddr_b2_sram_model.sv
module ddr_b2_sram_model #(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  parameter int AW     = 4
) (
  input  logic                     clk_hc,
  input  logic                     rst_n,
  input  logic                     ld_n,
  input  logic                     rw,
  input  logic [AW-1:0]            addr,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic [BYTE_W*NBYTES-1:0] dq_in,
  input  logic                     odt_en,
  output logic [BYTE_W*NBYTES-1:0] dq_out,
  output logic                     dq_oe,
  output logic                     qvalid,
  output logic                     term_en,
  output logic                     cq,
  output logic                     cq_n
);
  localparam int W     = BYTE_W * NBYTES;
  localparam int WW    = 2 * W;
  localparam int DEPTH = 1 << AW;

  logic          phase;
  logic [WW-1:0] mem [DEPTH];
  logic          wr_p, rd_p, rd_p2;
  logic [AW-1:0] wa, ra, ra2;
  logic [W-1:0]  wb1;
  logic [NBYTES-1:0] wm1;
  logic [WW-1:0] rhold, wnew;
  logic [6:0]    rsr;

  wire kedge  = ~phase;
  wire rd_cmd = kedge & ~ld_n & rw;

  assign cq   = phase;
  assign cq_n = ~phase;

  always_comb begin
    wnew = mem[wa];
    for (int b = 0; b < NBYTES; b++) begin
      if (!wm1[b])  wnew[b*BYTE_W +: BYTE_W]     = wb1[b*BYTE_W +: BYTE_W];
      if (!bw_n[b]) wnew[W + b*BYTE_W +: BYTE_W] = dq_in[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_hc) begin
    if (rst_n && kedge && wr_p) mem[wa] <= wnew;
  end

  always_ff @(posedge clk_hc or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      wr_p    <= 1'b0;
      rd_p    <= 1'b0;
      rd_p2   <= 1'b0;
      wa      <= '0;
      ra      <= '0;
      ra2     <= '0;
      wb1     <= '0;
      wm1     <= '1;
      rhold   <= '0;
      rsr     <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      qvalid  <= 1'b0;
      term_en <= 1'b0;
    end else begin
      phase <= ~phase;
      rsr   <= {rsr[5:0], rd_cmd};
      if (kedge) begin
        wr_p  <= ~ld_n & ~rw;
        rd_p  <= ~ld_n & rw;
        wa    <= addr;
        ra    <= addr;
        rd_p2 <= rd_p;
        ra2   <= ra;
        if (rd_p2) rhold <= mem[ra2];
      end else if (wr_p) begin
        wb1 <= dq_in;
        wm1 <= bw_n;
      end
      dq_oe   <= rsr[4] | rsr[5];
      qvalid  <= rsr[4] | rsr[5];
      dq_out  <= rsr[4] ? rhold[W-1:0] : (rsr[5] ? rhold[WW-1:W] : '0);
      term_en <= odt_en & ~(|rsr[6:3]);
    end
  end

  // R10
  term_drive_chk: assert property (@(posedge clk_hc) disable iff (!rst_n)
    dq_oe |-> !term_en);

  // R10
  term_lead_chk: assert property (@(posedge clk_hc) disable iff (!rst_n)
    $rose(dq_oe) |-> !$past(term_en));

  // R10
  term_odt_chk: assert property (@(posedge clk_hc) disable iff (!rst_n)
    !$past(odt_en) |-> !term_en);

  // R9
  qv_pair_chk: assert property (@(posedge clk_hc) disable iff (!rst_n)
    $rose(qvalid) |=> qvalid);

  // R5
  launch_phase_chk: assert property (@(posedge clk_hc) disable iff (!rst_n)
    $rose(dq_oe) |-> !cq);

  // R2
  cq_toggle_chk: assert property (@(posedge clk_hc) disable iff (!rst_n)
    $past(rst_n) |-> (cq != $past(cq)));
endmodule

// File: tb/ddr_b2_sram_model_tb_top.sv
module ddr_b2_sram_model_tb_top;
  localparam int AW = 4, NB = 2, BW = 9, W = BW * NB, DEPTH = 16;
  localparam int NK = 720, NT = 2 * NK + 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ld_n, rw, odt_en;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [W-1:0]  dq_in, dq_out;
  logic dq_oe, qvalid, term_en, cq, cq_n;

  ddr_b2_sram_model #(.BYTE_W(BW), .NBYTES(NB), .AW(AW)) dut_i (
    .clk_hc(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .bw_n(bw_n), .dq_in(dq_in), .odt_en(odt_en), .dq_out(dq_out),
    .dq_oe(dq_oe), .qvalid(qvalid), .term_en(term_en), .cq(cq), .cq_n(cq_n));

  int checks = 0, fails = 0;
  int cmd_k [NK];
  logic [AW-1:0] adr_k [NK];
  logic [W-1:0]  din_t [NT];
  logic [NB-1:0] bw_t [NT];
  logic          odt_t [NT], exp_oe [NT], rdoff [NT];
  logic [W-1:0]  exp_dq [NT];
  logic [2*W-1:0] refm [DEPTH];

  function automatic int unsigned hsh(input int unsigned v);
    int unsigned x;
    x = v + 32'h1234567;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    x = x * 32'h9E3779B1;
    return x ^ (x >> 15);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build();
    int unsigned h;
    for (int t = 0; t < NT; t++) begin
      h = hsh(t * 7 + 1);      din_t[t] = h[W-1:0];
      h = hsh(t * 11 + 3);     bw_t[t]  = h[NB-1:0];
      h = hsh(t * 13 + 5);
      odt_t[t]  = (t < NT / 2) ? 1'b1 : (h[1:0] != 2'b00);
      exp_oe[t] = 1'b0; rdoff[t] = 1'b0; exp_dq[t] = '0;
    end
    for (int k = 0; k < NK; k++) begin
      h = hsh(k + 1000);
      if (k < DEPTH) begin
        cmd_k[k] = 2; adr_k[k] = AW'(k);
        bw_t[2*k+1] = '0; bw_t[2*k+2] = '0;
      end else if (k < 2 * DEPTH) begin
        cmd_k[k] = 1; adr_k[k] = AW'(k - DEPTH);
      end else if (k >= NK - 6) begin
        cmd_k[k] = 0; adr_k[k] = h[AW+7:8];
      end else begin
        case (h % 5)
          0: cmd_k[k] = 0;
          1, 2: cmd_k[k] = 1;
          default: cmd_k[k] = 2;
        endcase
        adr_k[k] = h[AW+7:8];
      end
    end
    for (int k = 0; k < NK; k++) begin
      if (cmd_k[k] == 2) begin
        for (int b = 0; b < NB; b++) begin
          if (!bw_t[2*k+1][b]) refm[adr_k[k]][b*BW +: BW] = din_t[2*k+1][b*BW +: BW];
          if (!bw_t[2*k+2][b]) refm[adr_k[k]][W + b*BW +: BW] = din_t[2*k+2][b*BW +: BW];
        end
      end else if (cmd_k[k] == 1) begin
        exp_oe[2*k+5] = 1'b1; exp_dq[2*k+5] = refm[adr_k[k]][W-1:0];
        exp_oe[2*k+6] = 1'b1; exp_dq[2*k+6] = refm[adr_k[k]][2*W-1:W];
        for (int j = 4; j < 8; j++) rdoff[2*k+j] = 1'b1;
      end
    end
  endtask

  task automatic drive(input int t);
    int unsigned h;
    h = hsh(t * 17 + 9);
    odt_en = odt_t[t]; dq_in = din_t[t]; bw_n = bw_t[t];
    if (t % 2 == 0) begin
      ld_n = (cmd_k[t/2] == 0);
      rw   = (cmd_k[t/2] == 1) ? 1'b1 : (cmd_k[t/2] == 2) ? 1'b0 : h[0];
      addr = adr_k[t/2];
    end else begin
      ld_n = h[1]; rw = h[2]; addr = h[AW+3:4];
    end
  endtask

  task automatic check(input int t);
    logic te;
    te = odt_t[t] & ~rdoff[t];
    chk(cq == (t % 2 == 0) && cq_n == !cq, "R2 echo clock phase", W'(cq), W'(t % 2 == 0));
    chk(dq_oe == exp_oe[t], "R5 R8 output enable", W'(dq_oe), W'(exp_oe[t]));
    chk(qvalid == exp_oe[t], "R9 read valid", W'(qvalid), W'(exp_oe[t]));
    if (exp_oe[t])
      chk(dq_out == exp_dq[t], "R1 R3 R4 R5 R6 R7 read data", dq_out, exp_dq[t]);
    else
      chk(dq_out == '0, "R8 idle data", dq_out, '0);
    chk(term_en == te, "R10 termination", W'(term_en), W'(te));
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_n = 1'b1; rw = 1'b1; addr = '0; bw_n = '1; dq_in = '0; odt_en = 1'b1;
    build();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(dq_oe == 0 && qvalid == 0, "R11 reset enables", W'({dq_oe, qvalid}), '0);
    chk(term_en == 0 && cq == 0 && cq_n == 1, "R11 reset clocks/term", W'({term_en, cq, cq_n}), W'(1));
    chk(dq_out == '0, "R11 reset data", dq_out, '0);
    drive(0);
    rst_n = 1'b1;
    for (int t = 0; t < NT; t++) begin
      @(posedge clk);
      @(negedge clk);
      check(t);
      if (t + 1 < NT) drive(t + 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule